// File: doc/BRIEF.md
# USB Transmit Serializer with Bit Stuffing

This block turns bytes from a link layer into the symbol stream of a USB data line pair. A packet starts when the link raises `tx_valid`. The block sends the SYNC field, then each byte least significant bit first with NRZI encoding and zero-stuffing, and closes with an end-of-packet once the link lets `tx_valid` fall. Bytes are pulled with a one-cycle `tx_ready` strobe. The output is a two-bit line symbol plus a drive enable, ready for an analog driver outside this block.

Everything runs on a parallel-side clock. One serial bit slot passes on each cycle in which `bit_en` is high. A two-bit mode input picks normal encoding, a raw mode that maps bits straight onto the line, or a non-driving mode that releases the line so the device looks disconnected. Termination control, the analog driver and high-speed bit timing are outside the block.

Top module: `usbtx_serializer`

## Requirements
- R1: During and right after reset, `line_oe` and `tx_ready` are low and `line_out` shows J.
- R2: The first SYNC symbol is registered at the first edge with `bit_en` high at which `tx_valid` is sampled high in a driving mode. When `bit_en` is high every cycle, the line shows K with `line_oe` high one clock after `tx_valid` rises.
- R3: Line symbols are `line_out[0]` = positive wire and `line_out[1]` = negative wire, so J = 2'b01, K = 2'b10 and SE0 = 2'b00. In mode 0 the SYNC field on the line reads K J K J K J K K.
- R4: In mode 0 the data bits go out LSB first per byte. A 0 toggles the line level, a 1 keeps it, and the first data bit is taken relative to the last SYNC symbol.
- R5: In mode 0, after six consecutive 1 data bits a 0 is inserted and NRZI-encoded like data. The run count starts at the first data bit, and the rule also applies to a run that ends the last byte.
- R6: The link ends a packet by holding `tx_valid` low in a slot where `tx_ready` is high. Any due stuff bit is sent first. Then the line shows SE0, SE0, J, and `line_oe` drops in the next slot.
- R7: `tx_ready` is high for one clock only, in a slot with `bit_en` high that sends the last SYNC bit or the last bit of a byte. It is never high in stuffed-bit or EOP slots. The byte on `tx_data` at that edge is taken if `tx_valid` is high, so a packet of N bytes shows N+1 ready strobes.
- R8: Mode 2 (raw) sends 1 as J and 0 as K with no stuffing and no NRZI. The SYNC field reads K K K K K K K J, and the EOP is the same as in R6.
- R9: Mode 1 forces `line_oe` and `tx_ready` low in the same cycle and drops the packet. A return to mode 0 with `tx_valid` low leaves the line released.
- R10: Mode 3 is reserved and behaves as mode 1.
- R11: In a cycle after an edge with `bit_en` low (mode driving throughout), `line_out` and `line_oe` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parallel-side clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | One serial bit slot passes on each edge where this is high |
| mode | input | 2 | 0 normal, 1 non-driving, 2 raw, 3 reserved (non-driving) |
| tx_valid | input | 1 | Link has a packet in progress and a byte on `tx_data` |
| tx_data | input | DATA_W | Byte offered by the link |
| tx_ready | output | 1 | Byte on `tx_data` is taken at this edge |
| line_out | output | 2 | Line symbol {negative, positive} |
| line_oe | output | 1 | Line driver enable |

## Verification
The bench aims at runs of ones that cross byte edges and a run of exactly six that ends the last byte. A design that counted the SYNC tail, or that went straight to EOP, would put the stuff bit in the wrong place or leave it out, and the bench's decoder would flag that. It counts ready strobes per packet, which catches a design that pulls a byte during a stuffed or EOP slot and so skips or repeats data. It runs packets with sparse and random `bit_en`, which catches output that moves between slots. It also switches into the non-driving and reserved modes in the middle of a packet, where a design that waited for the end of the packet would keep driving the line.

// File: rtl/usbtx_pkg.sv
// Shared types for the USB transmit serializer.
// Assumes line symbols are {negative wire, positive wire}.
package usbtx_pkg;

    localparam logic [1:0] MODE_NORMAL = 2'd0;
    localparam logic [1:0] MODE_QUIET  = 2'd1;
    localparam logic [1:0] MODE_RAW    = 2'd2;
    localparam logic [1:0] MODE_RSVD   = 2'd3;

    localparam logic [1:0] LINE_J   = 2'b01;
    localparam logic [1:0] LINE_K   = 2'b10;
    localparam logic [1:0] LINE_SE0 = 2'b00;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SYNC,
        ST_DATA,
        ST_EOP
    } tx_state_e;

    // Kind of symbol that the controller asks the line stage to send.
    typedef enum logic [1:0] {
        SYM_IDLE,
        SYM_BIT,
        SYM_SE0,
        SYM_J
    } sym_kind_e;

    typedef struct packed {
        sym_kind_e kind;
        logic      val;
    } sym_t;

    // True for the modes in which the line is driven.
    function automatic logic mode_drives(input logic [1:0] m);
        return (m == MODE_NORMAL) || (m == MODE_RAW);
    endfunction

endpackage

// File: rtl/usbtx_ctrl.sv
// Packet sequencer: SYNC, data with stuffing decisions, EOP.
// Emits one symbol request per bit slot and pulls bytes via tx_ready.
// Assumes SYNC_LEN >= 2; a non-driving mode returns it to idle at once.
module usbtx_ctrl
    import usbtx_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int SYNC_LEN  = 8,
    parameter int STUFF_RUN = 6,
    parameter int EOP_SE0   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [1:0]        mode,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    output sym_t              sym
);

    localparam int WIDEST  = (DATA_W > SYNC_LEN) ? DATA_W : SYNC_LEN;
    localparam int CNT_TOP = (WIDEST > EOP_SE0 + 1) ? WIDEST : EOP_SE0 + 1;
    localparam int CNT_W   = $clog2(CNT_TOP);
    localparam int RUN_W   = $clog2(STUFF_RUN + 1);
    localparam logic [CNT_W-1:0] SYNC_LAST = CNT_W'(SYNC_LEN - 1);
    localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] EOP_LAST  = CNT_W'(EOP_SE0);
    localparam logic [RUN_W-1:0] RUN_LIMIT = RUN_W'(STUFF_RUN);

    tx_state_e         st;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] hold_q;
    logic [RUN_W-1:0]  ones;
    logic              drive;
    logic              raw;
    logic              stuff_due;
    logic              slot_ready;

    assign drive     = mode_drives(mode);
    assign raw       = (mode == MODE_RAW);
    assign stuff_due = !raw && (ones == RUN_LIMIT);
    assign tx_ready  = slot_ready && bit_en && drive;

    // Choose the symbol for the current slot and whether it ends a byte.
    always_comb begin
        sym        = '{SYM_IDLE, 1'b1};
        slot_ready = 1'b0;
        case (st)
            ST_IDLE: begin
                if (tx_valid) sym = '{SYM_BIT, 1'b0};
            end
            ST_SYNC: begin
                sym        = '{SYM_BIT, (cnt == SYNC_LAST)};
                slot_ready = (cnt == SYNC_LAST);
            end
            ST_DATA: begin
                if (stuff_due) begin
                    sym = '{SYM_BIT, 1'b0};
                end else begin
                    sym        = '{SYM_BIT, hold_q[0]};
                    slot_ready = (cnt == BYTE_LAST);
                end
            end
            ST_EOP: begin
                if (stuff_due)            sym = '{SYM_BIT, 1'b0};
                else if (cnt < EOP_LAST)  sym = '{SYM_SE0, 1'b0};
                else                      sym = '{SYM_J, 1'b1};
            end
            default: ;
        endcase
    end

    // Advance the packet sequence once per bit slot.
    always_ff @(posedge clk) begin
        if (!rst_n || !drive) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            ones   <= '0;
            hold_q <= '0;
        end else if (bit_en) begin
            case (st)
                ST_IDLE: begin
                    if (tx_valid) begin
                        st   <= ST_SYNC;
                        cnt  <= CNT_W'(1);
                        ones <= '0;
                    end
                end
                ST_SYNC: begin
                    if (cnt == SYNC_LAST) begin
                        cnt <= '0;
                        if (tx_valid) begin
                            hold_q <= tx_data;
                            st     <= ST_DATA;
                        end else begin
                            st <= ST_EOP;
                        end
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_DATA: begin
                    if (stuff_due) begin
                        ones <= '0;
                    end else begin
                        ones <= (raw || !hold_q[0]) ? '0 : ones + RUN_W'(1);
                        if (cnt == BYTE_LAST) begin
                            cnt <= '0;
                            if (tx_valid) hold_q <= tx_data;
                            else          st     <= ST_EOP;
                        end else begin
                            hold_q <= hold_q >> 1;
                            cnt    <= cnt + CNT_W'(1);
                        end
                    end
                end
                ST_EOP: begin
                    if (stuff_due) begin
                        ones <= '0;
                    end else if (cnt == EOP_LAST) begin
                        st  <= ST_IDLE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/usbtx_line.sv
// Line stage: turns symbol requests into registered J/K/SE0 and enable.
// NRZI in normal mode, direct mapping in raw mode; releases the line
// at once when the mode stops driving.
module usbtx_line
    import usbtx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       drive,
    input  logic       raw,
    input  sym_t       sym,
    output logic [1:0] line_q,
    output logic       oe_q
);

    logic lvl_j;
    logic sent_j;

    // Level of the next bit: direct in raw mode, NRZI otherwise.
    always_comb begin
        sent_j = raw ? sym.val : (sym.val ? lvl_j : !lvl_j);
    end

    // Register the line symbol and enable for each bit slot.
    always_ff @(posedge clk) begin
        if (!rst_n || !drive) begin
            line_q <= LINE_J;
            oe_q   <= 1'b0;
            lvl_j  <= 1'b1;
        end else if (bit_en) begin
            case (sym.kind)
                SYM_BIT: begin
                    oe_q   <= 1'b1;
                    line_q <= sent_j ? LINE_J : LINE_K;
                    lvl_j  <= sent_j;
                end
                SYM_SE0: begin
                    oe_q   <= 1'b1;
                    line_q <= LINE_SE0;
                end
                SYM_J: begin
                    oe_q   <= 1'b1;
                    line_q <= LINE_J;
                    lvl_j  <= 1'b1;
                end
                default: begin
                    oe_q   <= 1'b0;
                    line_q <= LINE_J;
                    lvl_j  <= 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/usbtx_serializer.sv
// Top of the USB transmit serializer: sequencer plus line stage.
// The mode input gates the line enable combinationally so a
// non-driving mode releases the line in the cycle it is applied.
module usbtx_serializer
    import usbtx_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int SYNC_LEN  = 8,
    parameter int STUFF_RUN = 6,
    parameter int EOP_SE0   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [1:0]        mode,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    output logic [1:0]        line_out,
    output logic              line_oe
);

    sym_t sym;
    logic oe_q;
    logic drive;

    assign drive   = mode_drives(mode);
    assign line_oe = oe_q && drive;

    usbtx_ctrl #(
        .DATA_W   (DATA_W),
        .SYNC_LEN (SYNC_LEN),
        .STUFF_RUN(STUFF_RUN),
        .EOP_SE0  (EOP_SE0)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .mode    (mode),
        .tx_valid(tx_valid),
        .tx_data (tx_data),
        .tx_ready(tx_ready),
        .sym     (sym)
    );

    usbtx_line u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .bit_en(bit_en),
        .drive (drive),
        .raw   (mode == MODE_RAW),
        .sym   (sym),
        .line_q(line_out),
        .oe_q  (oe_q)
    );

endmodule

// File: rtl/usbtx_serializer_chk.sv
// Property checker for the USB transmit serializer, bound to the top.
module usbtx_serializer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_en,
    input logic [1:0] mode,
    input logic       tx_ready,
    input logic [1:0] line_out,
    input logic       line_oe
);

    // R6: when the enable falls while driving, the last symbol was J.
    a_r6_release_after_j: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(line_oe) && (mode == 2'd0 || mode == 2'd2)
         && ($past(mode) == 2'd0 || $past(mode) == 2'd2))
        |-> ($past(line_out) == 2'b01));

    // R7: a ready strobe only appears in a bit slot while driving.
    a_r7_ready_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (bit_en && line_oe));

    // R9: non-driving mode releases the line and pulls no data.
    a_r9_quiet_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1) |-> (!line_oe && !tx_ready));

    // R10: reserved mode behaves as non-driving.
    a_r10_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3) |-> (!line_oe && !tx_ready));

    // R11: outputs hold across an edge without a bit slot.
    a_r11_hold_between_slots: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(bit_en) && (mode == 2'd0 || mode == 2'd2)
         && ($past(mode) == 2'd0 || $past(mode) == 2'd2))
        |-> ($stable(line_out) && $stable(line_oe)));

endmodule

bind usbtx_serializer usbtx_serializer_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_en  (bit_en),
    .mode    (mode),
    .tx_ready(tx_ready),
    .line_out(line_out),
    .line_oe (line_oe)
);

// File: tb/usbtx_serializer_test.sv
module usbtx_serializer_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] LJ = 2'b01;
    localparam logic [1:0] LK = 2'b10;
    localparam logic [1:0] LSE0 = 2'b00;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = 8'h00;
    wire        tx_ready;
    wire [1:0]  line_out;
    wire        line_oe;

    usbtx_serializer uut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .mode(mode),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .line_out(line_out), .line_oe(line_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int div = 1;
    int phase = 0;
    bit slot_seen = 1'b0;
    bit rec_on = 1'b0;
    bit finished = 1'b0;
    logic [2:0] cap [0:2047];
    int ncap = 0;
    int rdy_cnt = 0;
    int hold_err = 0;
    logic [1:0] prev_line = 2'b01;
    logic [7:0] pk [0:15];

    // Bit-slot enable pattern: every cycle, every div-th cycle, or random.
    always @(posedge clk) begin
        slot_seen = bit_en;
        #1;
        if (div == 1)      bit_en = 1'b1;
        else if (div == 0) bit_en = 1'($urandom % 2);
        else begin
            phase  = (phase + 1) % div;
            bit_en = (phase == 0);
        end
    end

    // Mid-cycle monitor: record slot symbols, ready strobes, holds.
    always @(negedge clk) begin
        if (rec_on) begin
            if (slot_seen && ncap < 2048) begin
                cap[ncap] = {line_oe, line_out};
                ncap++;
            end
            if (!slot_seen && line_out != prev_line) hold_err++;
            if (tx_ready) rdy_cnt++;
        end
        prev_line = line_out;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected SYNC symbol k in normal or raw mode.
    function automatic logic [1:0] sync_sym(input bit raw, input int k);
        if (raw) return (k == 7) ? LJ : LK;
        return (k % 2 == 0 || k == 7) ? LK : LJ;
    endfunction

    // Link side: offer pk[0..len-1], advance on each taken strobe.
    task automatic send(input int len, input bit lat);
        int idx;
        int k;
        bit acc;
        ncap = 0; rdy_cnt = 0; hold_err = 0; rec_on = 1'b1;
        @(posedge clk); #1;
        tx_valid = 1'b1;
        tx_data  = pk[0];
        idx = 0; k = 0;
        while (idx < len) begin
            @(negedge clk);
            if (lat && k == 0)
                chk(!line_oe, "R2", "enable before first edge", int'(line_oe), 0);
            if (lat && k == 1)
                chk(line_oe && line_out == LK, "R2", "K one clock after valid",
                    int'({line_oe, line_out}), int'({1'b1, LK}));
            acc = tx_ready;
            k++;
            @(posedge clk); #1;
            if (acc) begin
                idx++;
                if (idx < len) tx_data = pk[idx];
                else begin
                    tx_valid = 1'b0;
                    tx_data  = 8'($urandom);
                end
            end
        end
        repeat (300) @(posedge clk);
        #1;
        rec_on = 1'b0;
    endtask

    // Bench decoder: check SYNC, unstuff/NRZI-decode data, EOP, strobes.
    task automatic decode(input bit raw, input int len, input string tag);
        int i;
        int nb;
        int ones;
        int serr;
        int symerr;
        int derr;
        int eerr;
        logic [1:0] prev;
        logic [1:0] s;
        bit b;
        logic [7:0] got [0:15];
        for (int g = 0; g < 16; g++) got[g] = 8'h00;
        i = 0;
        while (i < ncap && !cap[i][2]) i++;
        symerr = 0;
        for (int k = 0; k < 8; k++) begin
            if (i >= ncap || cap[i] != {1'b1, sync_sym(raw, k)}) symerr++;
            i++;
        end
        chk(symerr == 0, raw ? "R8" : "R3", {tag, " sync field"}, symerr, 0);
        prev = LK; nb = 0; ones = 0; serr = 0;
        while (i < ncap && cap[i][2] && cap[i][1:0] != LSE0) begin
            s = cap[i][1:0];
            i++;
            if (s == 2'b11) begin serr++; continue; end
            if (raw) b = (s == LJ);
            else begin
                b = (s == prev);
                prev = s;
                if (ones == 6) begin
                    if (b) serr++;
                    ones = 0;
                    continue;
                end
                ones = b ? ones + 1 : 0;
            end
            if (nb < 128) got[nb / 8][nb % 8] = b;
            nb++;
        end
        if (!raw && ones == 6) serr++;
        derr = 0;
        if (nb != len * 8) derr++;
        else for (int k = 0; k < len; k++) if (got[k] != pk[k]) derr++;
        chk(derr == 0, raw ? "R8" : "R4", {tag, " data bit count"}, nb, len * 8);
        if (!raw) chk(serr == 0, "R5", {tag, " stuff errors"}, serr, 0);
        eerr = 0;
        for (int k = 0; k < 3; k++) begin
            if (i + k >= ncap || cap[i + k] != {1'b1, (k < 2) ? LSE0 : LJ}) eerr++;
        end
        if (i + 3 >= ncap || cap[i + 3][2]) eerr++;
        chk(eerr == 0, "R6", {tag, " EOP symbols"}, eerr, 0);
        chk(rdy_cnt == len + 1, "R7", {tag, " ready strobes"}, rdy_cnt, len + 1);
    endtask

    task automatic fill_random(input int len);
        for (int k = 0; k < len; k++)
            pk[k] = ($urandom % 4 == 0) ? 8'hFF : 8'($urandom);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int bad;
        int len;
        void'($urandom(32'h00C0FFEE));

        // R1: reset state
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(!line_oe && !tx_ready && line_out == LJ, "R1", "outputs in reset",
            int'({line_oe, tx_ready, line_out}), int'({1'b0, 1'b0, LJ}));
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!line_oe && !tx_ready && line_out == LJ, "R1", "outputs after reset",
            int'({line_oe, tx_ready, line_out}), int'({1'b0, 1'b0, LJ}));

        // R2/R3/R4: directed short packet with latency check
        div = 1;
        pk[0] = 8'hA5; pk[1] = 8'h3C;
        send(2, 1'b1);
        decode(1'b0, 2, "two bytes");

        // R5/R6: run of six ones ends the last byte, stuff before EOP
        pk[0] = 8'hFC;
        send(1, 1'b0);
        decode(1'b0, 1, "stuff before EOP");

        // R5/R7: long runs of ones across byte edges
        for (int k = 0; k < 4; k++) pk[k] = 8'hFF;
        send(4, 1'b0);
        decode(1'b0, 4, "all ones");

        // R11: sparse bit slots
        div = 4;
        pk[0] = 8'hFF; pk[1] = 8'h7E; pk[2] = 8'h01;
        send(3, 1'b0);
        decode(1'b0, 3, "sparse slots");
        chk(hold_err == 0, "R11", "line moved between slots", hold_err, 0);

        // Random packets, normal mode, varied slot patterns
        for (int p = 0; p < 10; p++) begin
            div = int'($urandom % 4);
            len = 1 + int'($urandom % 8);
            fill_random(len);
            send(len, 1'b0);
            decode(1'b0, len, "random normal");
            chk(hold_err == 0, "R11", "random hold", hold_err, 0);
        end

        // R8: raw mode
        div = 1;
        @(posedge clk); #1;
        mode = 2'd2;
        pk[0] = 8'hFF; pk[1] = 8'h80;
        send(2, 1'b0);
        decode(1'b1, 2, "raw directed");
        for (int p = 0; p < 3; p++) begin
            div = int'($urandom % 3);
            len = 1 + int'($urandom % 5);
            fill_random(len);
            send(len, 1'b0);
            decode(1'b1, len, "raw random");
        end
        @(posedge clk); #1;
        mode = 2'd0;
        div = 1;

        // R9: non-driving mode in mid-packet
        tx_data = 8'h81;
        tx_valid = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(line_oe, "R9", "driving before switch", int'(line_oe), 1);
        @(posedge clk); #1;
        mode = 2'd1;
        @(negedge clk);
        chk(!line_oe && !tx_ready, "R9", "released in same cycle",
            int'({line_oe, tx_ready}), 0);
        bad = 0;
        repeat (20) begin
            @(negedge clk);
            if (line_oe || tx_ready) bad++;
        end
        chk(bad == 0, "R9", "stays released with valid high", bad, 0);

        // R10: reserved mode
        @(posedge clk); #1;
        mode = 2'd3;
        bad = 0;
        repeat (20) begin
            @(negedge clk);
            if (line_oe || tx_ready) bad++;
        end
        chk(bad == 0, "R10", "reserved mode released", bad, 0);

        // R9: back to normal with valid low, no resumed packet
        @(posedge clk); #1;
        tx_valid = 1'b0;
        mode = 2'd0;
        bad = 0;
        repeat (30) begin
            @(negedge clk);
            if (line_oe) bad++;
        end
        chk(bad == 0, "R9", "dropped packet not resumed", bad, 0);

        // Recovery packet after the abort
        pk[0] = 8'h5A;
        send(1, 1'b0);
        decode(1'b0, 1, "after abort");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule